// File: doc/BRIEF.md
# Pipelined SM4 Block Cipher Engine

This block encrypts or decrypts one 128-bit block per clock with the SM4 cipher. All 32 rounds are unrolled into 32 register stages. A block enters with a valid flag and a per-block direction bit. The result comes out a fixed number of cycles later, and its valid flag and direction bit travel through the pipeline with it. Encryption and decryption share the same stages. A decrypting block reads the round-key bank from the top index down, and an encrypting block reads it from index zero up.

A 128-bit master key is loaded before any data. The key is first XORed with four fixed words. One key-round unit then runs 32 sequential rounds, one per cycle. Each round uses a constant whose bytes are computed from the round index, and it writes one 32-bit round key into a register bank. The ready flag is low while this runs. A block offered while the flag is low is dropped. The block has no data buffering, no flow control and no modes of operation around the cipher core.

Top module: `sm4_pipe_engine`

## Requirements
- R1: While rst_ni is low and right after it is released, out_valid_o and key_ready_o are 0.
- R2: key_ready_o stays 0 from reset until the first key expansion completes. A key_load_i pulse sampled at a clock edge drives key_ready_o to 0 after that edge, holds it at 0 for 32 cycles, and returns it to 1 in the 33rd cycle after the load.
- R3: When in_valid_i is 1 at an edge where key_ready_o is 0, no output is produced for that block.
- R4: With key 0123456789ABCDEFFEDCBA9876543210 loaded, encrypting (in_decrypt_i = 0) that same value yields 681EDF34D206965E86B3E94F536E4246.
- R5: With the same key, decrypting (in_decrypt_i = 1) 681EDF34D206965E86B3E94F536E4246 yields 0123456789ABCDEFFEDCBA9876543210.
- R6: A block accepted at edge t shows out_valid_o = 1 in the cycle after edge t+31, which is exactly 32 cycles later. Back-to-back blocks are accepted every cycle with no stall.
- R7: out_decrypt_o equals the in_decrypt_i of the block being output, even when the direction changes from one cycle to the next.
- R8: For any key and block, the result matches the cipher definition. Round key i (i = 0..31) is the new low word of key round i, and round constant i has bytes ((4i+j)*7) mod 256 for j = 0..3, most significant first. Encryption applies keys 0..31 and decryption applies 31..0. The output is the final four state words in reversed order, with the most significant word of a block being word 0.
- R9: A new key load replaces every round key. Blocks accepted after key_ready_o returns to 1 are processed with the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_load_i | input | 1 | Start key expansion from key_i |
| key_i | input | 128 | Master key, most significant word first |
| key_ready_o | output | 1 | Round keys are valid and data is accepted |
| in_valid_i | input | 1 | Input block valid |
| in_decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt |
| in_block_i | input | 128 | Input block |
| out_valid_o | output | 1 | Result valid |
| out_decrypt_o | output | 1 | Direction of the block being output |
| out_block_o | output | 128 | Result block |

## Verification
Each result is due 32 cycles after its input is driven. The key ready flag is due to fall one cycle after a load and to rise 33 cycles after it. The bench counts clock edges and stamps every accepted block with the cycle number at which its result must appear. At each falling edge it compares the output against the oldest stamp, and it flags any result that comes early, comes late or appears without a matching accepted block. It also predicts the ready flag for every cycle from the cycle of the last load, and it drains the pipeline before each new key load so that no block in flight sees a mix of round keys.

// File: rtl/sm4p_pkg.sv
package sm4p_pkg;
  typedef logic [31:0]  word_t;
  typedef logic [127:0] blk_t;

  localparam blk_t FK_MASK = {32'hA3B1BAC6, 32'h56AA3350, 32'h677D9197, 32'hB27022DC};

  // substitution table, 16 bytes per row, row = high nibble, byte 0 at msb
  localparam logic [127:0] SBOX_ROWS [16] = '{
    128'hd690e9fecce13db716b614c228fb2c05,
    128'h2b679a762abe04c3aa44132649860699,
    128'h9c4250f491ef987a33540b43edcfac62,
    128'he4b31ca9c908e89580df94fa758f3fa6,
    128'h4707a7fcf37317ba83593c19e6854fa8,
    128'h686b81b27164da8bf8eb0f4b70569d35,
    128'h1e240e5e6358d1a225227c3b01217887,
    128'hd40046579fd327524c3602e7a0c4c89e,
    128'heabf8ad240c738b5a3f7f2cef96115a1,
    128'he0ae5da49b341a55ad933230f58cb1e3,
    128'h1df6e22e8266ca60c02923ab0d534e6f,
    128'hd5db3745defd8e2f03ff6a726d6c5b51,
    128'h8d1baf92bbddbc7f11d95c411f105ad8,
    128'h0ac13188a5cd7bbd2d74d012b8e5b4b0,
    128'h8969974a0c96777e65b9f109c56ec684,
    128'h18f07dec3adc4d2079ee5f3ed7cb3948
  };

  function automatic logic [7:0] sbox_lookup(input logic [7:0] x);
    logic [127:0] row;
    row = SBOX_ROWS[x[7:4]];
    return row[{~x[3:0], 3'b000} +: 8];
  endfunction

  function automatic word_t rotl(input word_t w, input int unsigned n);
    return (w << n) | (w >> (32 - n));
  endfunction

  function automatic word_t lin_data(input word_t b);
    return b ^ rotl(b, 2) ^ rotl(b, 10) ^ rotl(b, 18) ^ rotl(b, 24);
  endfunction

  function automatic word_t lin_key(input word_t b);
    return b ^ rotl(b, 13) ^ rotl(b, 23);
  endfunction

  function automatic word_t ck_word(input logic [7:0] idx);
    word_t w;
    for (int j = 0; j < 4; j++) w[8*(3-j) +: 8] = 8'((int'(idx) * 4 + j) * 7);
    return w;
  endfunction
endpackage

// File: rtl/sm4_sbox_lane.sv
module sm4_sbox_lane (
  input  logic [7:0] a_i,
  output logic [7:0] y_o
);
  assign y_o = sm4p_pkg::sbox_lookup(a_i);
endmodule

// File: rtl/sm4_tau.sv
module sm4_tau
  import sm4p_pkg::*;
#(
  parameter int LANES = 4
) (
  input  word_t a_i,
  output word_t b_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sm4_sbox_lane u_lane (
      .a_i(a_i[8*l +: 8]),
      .y_o(b_o[8*l +: 8])
    );
  end
endmodule

// File: rtl/sm4_round_stage.sv
module sm4_round_stage
  import sm4p_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  logic  dec_i,
  input  blk_t  state_i,
  input  word_t rkey_i,
  output logic  valid_o,
  output logic  dec_o,
  output blk_t  state_o
);
  word_t w0, w1, w2, w3, mix, sub;

  assign {w0, w1, w2, w3} = state_i;
  assign mix = w1 ^ w2 ^ w3 ^ rkey_i;

  sm4_tau u_tau (
    .a_i(mix),
    .b_o(sub)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  // payload carries no reset: only the valid bit qualifies it
  always_ff @(posedge clk_i) begin
    dec_o   <= dec_i;
    state_o <= {w1, w2, w3, w0 ^ lin_data(sub)};
  end
endmodule

// File: rtl/sm4_key_sched.sv
module sm4_key_sched
  import sm4p_pkg::*;
#(
  parameter int ROUNDS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  blk_t                  key_i,
  output logic                  ready_o,
  output logic [ROUNDS*32-1:0]  rk_flat_o
);
  localparam int CW = $clog2(ROUNDS);
  localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);

  logic          busy_q, have_q;
  logic [CW-1:0] cnt_q;
  blk_t          kst_q;
  word_t         rk_q [ROUNDS];
  word_t         mix, sub, next_word;

  assign mix       = kst_q[95:64] ^ kst_q[63:32] ^ kst_q[31:0] ^ ck_word(8'(cnt_q));
  assign next_word = kst_q[127:96] ^ lin_key(sub);
  assign ready_o   = have_q;

  sm4_tau u_tau (
    .a_i(mix),
    .b_o(sub)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      have_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      have_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        have_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (load_i) kst_q <= key_i ^ FK_MASK;
    else if (busy_q) kst_q <= {kst_q[95:0], next_word};
  end

  always_ff @(posedge clk_i) begin
    if (busy_q && !load_i) rk_q[cnt_q] <= next_word;
  end

  for (genvar i = 0; i < ROUNDS; i++) begin : g_rk
    assign rk_flat_o[32*i +: 32] = rk_q[i];
  end
endmodule

// File: rtl/sm4_pipe_engine.sv
module sm4_pipe_engine
  import sm4p_pkg::*;
#(
  parameter int ROUNDS = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         key_load_i,
  input  logic [127:0] key_i,
  output logic         key_ready_o,
  input  logic         in_valid_i,
  input  logic         in_decrypt_i,
  input  logic [127:0] in_block_i,
  output logic         out_valid_o,
  output logic         out_decrypt_o,
  output logic [127:0] out_block_o
);
  localparam int NWORDS = 4;

  logic [ROUNDS*32-1:0] rk_flat;
  logic [ROUNDS:0]      v_chain, d_chain;
  blk_t                 s_chain [ROUNDS+1];
  blk_t                 last;

  sm4_key_sched #(.ROUNDS(ROUNDS)) u_keys (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (key_load_i),
    .key_i    (key_i),
    .ready_o  (key_ready_o),
    .rk_flat_o(rk_flat)
  );

  assign v_chain[0] = in_valid_i & key_ready_o;
  assign d_chain[0] = in_decrypt_i;
  assign s_chain[0] = in_block_i;

  for (genvar i = 0; i < ROUNDS; i++) begin : g_stage
    word_t rk_enc, rk_dec, rk_sel;
    assign rk_enc = rk_flat[32*i +: 32];
    assign rk_dec = rk_flat[32*(ROUNDS-1-i) +: 32];
    assign rk_sel = d_chain[i] ? rk_dec : rk_enc;

    sm4_round_stage u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(v_chain[i]),
      .dec_i  (d_chain[i]),
      .state_i(s_chain[i]),
      .rkey_i (rk_sel),
      .valid_o(v_chain[i+1]),
      .dec_o  (d_chain[i+1]),
      .state_o(s_chain[i+1])
    );
  end

  assign last          = s_chain[ROUNDS];
  assign out_valid_o   = v_chain[ROUNDS];
  assign out_decrypt_o = d_chain[ROUNDS];

  // final word reversal
  for (genvar w = 0; w < NWORDS; w++) begin : g_rev
    assign out_block_o[32*w +: 32] = last[32*(NWORDS-1-w) +: 32];
  end
endmodule

// File: rtl/sm4_pipe_engine_chk.sv
module sm4_pipe_engine_chk #(
  parameter int ROUNDS = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic key_load_i,
  input logic key_ready_o,
  input logic in_valid_i,
  input logic in_decrypt_i,
  input logic out_valid_o,
  input logic out_decrypt_o
);
  localparam int SW = $clog2(ROUNDS + 2) + 1;
  localparam logic [SW-1:0] LIM = SW'(ROUNDS);

  logic [ROUNDS-1:0] vsh, dsh;
  logic              seen_q;
  logic [SW-1:0]     since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vsh     <= '0;
      dsh     <= '0;
      seen_q  <= 1'b0;
      since_q <= '0;
    end else begin
      vsh <= {vsh[ROUNDS-2:0], in_valid_i & key_ready_o};
      dsh <= {dsh[ROUNDS-2:0], in_decrypt_i};
      if (key_load_i) begin
        seen_q  <= 1'b1;
        since_q <= '0;
      end else if (since_q < LIM) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R1: assert (!out_valid_o && !key_ready_o);
  end

  assert_ready_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_load_i |=> !key_ready_o);

  assert_ready_hold_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q || since_q < LIM) |-> !key_ready_o);

  assert_ready_return_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && since_q >= LIM) |-> key_ready_o);

  // R3 and R6: output valid appears exactly for accepted blocks, ROUNDS cycles later
  assert_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == vsh[ROUNDS-1]);

  assert_mode_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_decrypt_o == dsh[ROUNDS-1]));
endmodule

bind sm4_pipe_engine sm4_pipe_engine_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .key_load_i   (key_load_i),
  .key_ready_o  (key_ready_o),
  .in_valid_i   (in_valid_i),
  .in_decrypt_i (in_decrypt_i),
  .out_valid_o  (out_valid_o),
  .out_decrypt_o(out_decrypt_o)
);

// File: tb/sm4_pipe_engine_test.sv
module sm4_pipe_engine_test;
  localparam logic [127:0] KAT_PT = 128'h0123456789abcdeffedcba9876543210;
  localparam logic [127:0] KAT_CT = 128'h681edf34d206965e86b3e94f536e4246;

  localparam logic [127:0] REF_ROWS [16] = '{
    128'hd690e9fecce13db716b614c228fb2c05, 128'h2b679a762abe04c3aa44132649860699,
    128'h9c4250f491ef987a33540b43edcfac62, 128'he4b31ca9c908e89580df94fa758f3fa6,
    128'h4707a7fcf37317ba83593c19e6854fa8, 128'h686b81b27164da8bf8eb0f4b70569d35,
    128'h1e240e5e6358d1a225227c3b01217887, 128'hd40046579fd327524c3602e7a0c4c89e,
    128'heabf8ad240c738b5a3f7f2cef96115a1, 128'he0ae5da49b341a55ad933230f58cb1e3,
    128'h1df6e22e8266ca60c02923ab0d534e6f, 128'hd5db3745defd8e2f03ff6a726d6c5b51,
    128'h8d1baf92bbddbc7f11d95c411f105ad8, 128'h0ac13188a5cd7bbd2d74d012b8e5b4b0,
    128'h8969974a0c96777e65b9f109c56ec684, 128'h18f07dec3adc4d2079ee5f3ed7cb3948
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic         key_load_i = 1'b0;
  logic [127:0] key_i = '0;
  logic         key_ready_o;
  logic         in_valid_i = 1'b0;
  logic         in_decrypt_i = 1'b0;
  logic [127:0] in_block_i = '0;
  logic         out_valid_o;
  logic         out_decrypt_o;
  logic [127:0] out_block_o;

  int n_chk = 0, n_fail = 0, cyc = 0, load_cyc = 0;
  bit loaded = 0, done = 0;
  logic [31:0] brk [32];

  int           due_q [$];
  logic [127:0] blk_q [$];
  bit           mode_q [$];
  string        tag_q [$];

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  sm4_pipe_engine uut (.*);

  function automatic logic [7:0] ref_s(input logic [7:0] x);
    logic [127:0] r;
    r = REF_ROWS[int'(x) / 16] >> (8 * (15 - int'(x) % 16));
    return r[7:0];
  endfunction

  function automatic logic [31:0] rl(input logic [31:0] w, input int n);
    return (w << n) | (w >> (32 - n));
  endfunction

  function automatic logic [31:0] ref_tau(input logic [31:0] w);
    return {ref_s(w[31:24]), ref_s(w[23:16]), ref_s(w[15:8]), ref_s(w[7:0])};
  endfunction

  function automatic void ref_expand(input logic [127:0] key);
    logic [31:0] k [4];
    logic [31:0] t, c;
    logic [127:0] m;
    m = key ^ {32'hA3B1BAC6, 32'h56AA3350, 32'h677D9197, 32'hB27022DC};
    for (int i = 0; i < 4; i++) k[i] = m[127-32*i -: 32];
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 4; j++) c[31-8*j -: 8] = 8'(((4 * i + j) * 7) % 256);
      t = ref_tau(k[1] ^ k[2] ^ k[3] ^ c);
      t = k[0] ^ t ^ rl(t, 13) ^ rl(t, 23);
      brk[i] = t;
      k[0] = k[1]; k[1] = k[2]; k[2] = k[3]; k[3] = t;
    end
  endfunction

  function automatic logic [127:0] ref_crypt(input logic [127:0] b, input bit dec);
    logic [31:0] x [4];
    logic [31:0] t;
    for (int i = 0; i < 4; i++) x[i] = b[127-32*i -: 32];
    for (int r = 0; r < 32; r++) begin
      t = ref_tau(x[1] ^ x[2] ^ x[3] ^ (dec ? brk[31-r] : brk[r]));
      t = x[0] ^ t ^ rl(t, 2) ^ rl(t, 10) ^ rl(t, 18) ^ rl(t, 24);
      x[0] = x[1]; x[1] = x[2]; x[2] = x[3]; x[3] = t;
    end
    return {x[3], x[2], x[1], x[0]};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    bit exp_ready;
    exp_ready = loaded && (cyc - load_cyc) >= 33;
    chk(key_ready_o == exp_ready, "R2 key_ready_o", 128'(key_ready_o), 128'(exp_ready));
    if (out_valid_o) begin
      if (due_q.size() == 0) begin
        chk(1'b0, "R3 output without accepted block", 128'(out_valid_o), 128'h0);
      end else begin
        chk(due_q[0] == cyc, "R6 latency cycle", 128'(cyc), 128'(due_q[0]));
        chk(out_block_o == blk_q[0], tag_q[0], out_block_o, blk_q[0]);
        chk(out_decrypt_o == mode_q[0], "R7 direction bit", 128'(out_decrypt_o), 128'(mode_q[0]));
        void'(due_q.pop_front()); void'(blk_q.pop_front());
        void'(mode_q.pop_front()); void'(tag_q.pop_front());
      end
    end else if (due_q.size() > 0 && due_q[0] <= cyc) begin
      chk(1'b0, "R6 missing output", 128'(cyc), 128'(due_q[0]));
      void'(due_q.pop_front()); void'(blk_q.pop_front());
      void'(mode_q.pop_front()); void'(tag_q.pop_front());
    end
  endtask

  task automatic step(input bit ld, input logic [127:0] key, input bit v, input bit dec,
                      input logic [127:0] blk, input bit use_ovr, input logic [127:0] ovr,
                      input string tag);
    bit rdy;
    @(negedge clk_i);
    check_outputs();
    rdy = loaded && (cyc - load_cyc) >= 33;
    key_load_i   = ld;
    key_i        = key;
    in_valid_i   = v;
    in_decrypt_i = dec;
    in_block_i   = blk;
    if (v && rdy) begin
      due_q.push_back(cyc + 32);
      blk_q.push_back(use_ovr ? ovr : ref_crypt(blk, dec));
      mode_q.push_back(dec);
      tag_q.push_back(tag);
    end
    if (ld) begin
      loaded = 1;
      load_cyc = cyc;
      ref_expand(key);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, '0, 0, '0, "idle");
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1 out_valid_o in reset", 128'(out_valid_o), 128'h0);
    chk(key_ready_o == 1'b0, "R1 key_ready_o in reset", 128'(key_ready_o), 128'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1 out_valid_o after reset", 128'(out_valid_o), 128'h0);
    chk(key_ready_o == 1'b0, "R1 key_ready_o after reset", 128'(key_ready_o), 128'h0);

    // R3: blocks offered before any key are dropped
    for (int i = 0; i < 6; i++) step(0, '0, 1, i[0], rnd128(), 0, '0, "R3 no key");
    // R2: load the test key while still offering blocks
    step(1, KAT_PT, 1, 0, rnd128(), 0, '0, "R3 load");
    for (int i = 0; i < 36; i++) step(0, '0, 1, i[1], rnd128(), 0, '0, "R3/R8 during expansion");
    idle(34);

    // R4 and R5 known answers
    step(0, '0, 1, 0, KAT_PT, 1, KAT_CT, "R4 encrypt known answer");
    step(0, '0, 1, 1, KAT_CT, 1, KAT_PT, "R5 decrypt known answer");
    idle(34);

    // R6/R7/R8: every byte value through every lane, alternating direction each cycle
    for (int b = 0; b < 256; b++)
      step(0, '0, 1, b[0], {$urandom, {4{8'(b)}}, 64'h0}, 0, '0, "R8 byte sweep");
    for (int i = 0; i < 64; i++)
      step(0, '0, (i % 5) != 3, $urandom % 2, rnd128(), 0, '0, "R8 random gaps");
    idle(34);

    // R9: replace the key, keep offering blocks while the expansion runs
    step(1, rnd128(), 0, 0, '0, 0, '0, "R9 reload");
    for (int i = 0; i < 40; i++) step(0, '0, 1, $urandom % 2, rnd128(), 0, '0, "R9 new key");
    for (int k = 0; k < 3; k++) begin
      idle(34);
      step(1, rnd128(), 0, 0, '0, 0, '0, "R9 reload");
      idle(33);
      for (int i = 0; i < 48; i++) step(0, '0, 1, $urandom % 2, rnd128(), 0, '0, "R9 new key");
    end
    idle(36);
    chk(due_q.size() == 0, "R6 results outstanding", 128'(due_q.size()), 128'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule